// File: doc/BRIEF.md
# Per-Priority Pause Engine with Stall Watchdog

This block decides, for one link, when each of its traffic classes must be held back at the far end. It keeps a byte count of how full the local ingress buffer is for every priority, using enqueue and dequeue events. When the count for a class climbs to its stop level, the block asks the link partner to hold only that class, with a pause time. When the count falls below a lower restart level, it asks the partner to release that class with a zero pause time. All other classes keep flowing. The stop level is set below the buffer capacity by a headroom parameter. That headroom absorbs the bytes already on the wire and in the partner's MAC when the request goes out.

While a class stays held, the block repeats the hold request before the advertised pause time runs out. The pause time is measured in quanta of a fixed number of clock cycles.

On the egress side, a watchdog runs for each priority queue. It watches for a queue that the partner keeps paused while the queue holds data and sends nothing. After a timeout, the watchdog raises a forced-drop enable for that queue. This breaks the stall locally, without waiting for the partner to stop pausing. The drop mode ends once the queue has drained and the pause has been lifted for a restore interval. Per-priority counters record hold requests sent, pause frames received and watchdog trips.

Top module: `pfc_pause_engine`

## Requirements
- R1: While reset is asserted, and immediately after it is released, every output is zero: no request, no drop enable, and all counters at zero.
- R2: Each priority keeps its own occupancy. An enqueue adds bytes only to the priority it names, and a dequeue subtracts bytes only from the priority it names. When both events target the same priority in the same cycle, the net change is applied. A dequeue larger than the current count leaves the count at zero.
- R3: The stop level of a priority is BUF_BYTES minus HEADROOM_BYTES. On the clock edge where an unpaused priority's updated occupancy reaches that level or more, the block issues a request with only that priority's enable bit set. That priority's field carries PAUSE_QUANTA.
- R4: The restart level is the stop level minus RESUME_GAP. On the edge where a paused priority's updated occupancy drops below the restart level, the block issues a request with that priority's field at zero. No request is issued for occupancies between the two levels, and a release request is only ever sent after a hold request for the same priority.
- R5: While a priority stays held, a new hold request with PAUSE_QUANTA is issued every REFRESH_CYC cycles after the previous one. REFRESH_CYC must be shorter than PAUSE_QUANTA times CYC_PER_QUANTUM.
- R6: The drop enable of a queue is set on the edge that completes WD_TIMEOUT consecutive cycles in which that queue is paused by the partner, is non-empty, and has no dequeue. Any dequeue restarts the count.
- R7: A set drop enable is cleared after RESTORE_CYC consecutive cycles in which the queue is both empty and not paused. While the queue is still paused, the enable stays set.
- R8: The drop enable is set and held even though the partner keeps its pause asserted. No change from the partner is needed to leave the stall.
- R9: For each priority, cnt_xoff_sent counts hold requests sent, including refreshes; release requests are not counted. cnt_rx_pfc counts received pause frames whose enable bit for that priority is set. cnt_wd_trip counts drop-enable rising edges. Each counter is CW bits wide, and saturates unless CNT_WRAP is set.
- R10: Requests from several priorities on the same edge are merged into one request. The merged request has one enable bit per priority, and each priority's time sits in field tx_pfc_time[i*QW +: QW]. tx_pfc_vld is high exactly when at least one enable bit is set. A priority that is not enabled has a zero field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_enq_vld | input | 1 | Ingress enqueue event |
| in_enq_prio | input | PW | Priority of the enqueue |
| in_enq_bytes | input | BYTE_W | Bytes enqueued |
| in_deq_vld | input | 1 | Ingress dequeue event |
| in_deq_prio | input | PW | Priority of the dequeue |
| in_deq_bytes | input | BYTE_W | Bytes dequeued |
| eg_paused | input | NP | Partner pause state per egress queue |
| eg_nonempty | input | NP | Egress queue holds data |
| eg_deq | input | NP | Egress queue sent data this cycle |
| rx_pfc_vld | input | 1 | A pause frame was received |
| rx_pfc_en | input | NP | Priority enable vector of that frame |
| tx_pfc_vld | output | 1 | Request to send a pause frame |
| tx_pfc_en | output | NP | Priorities carried by the request |
| tx_pfc_time | output | NP*QW | Pause time per priority, zero means release |
| eg_drop_en | output | NP | Forced-drop enable per egress queue |
| cnt_xoff_sent | output | NP*CW | Hold requests sent per priority |
| cnt_rx_pfc | output | NP*CW | Pause frames received per priority |
| cnt_wd_trip | output | NP*CW | Watchdog trips per priority |

## Verification
A hold decision on one priority and a release decision on another can land on the same edge, and so can an enqueue and a dequeue on a single priority. The bench provokes the first case by enqueuing past the stop level on one class while the same cycle's dequeue drops a held class below its restart level. It then expects one merged request, with one field at PAUSE_QUANTA and the other at zero. For the second case, it enqueues and dequeues on one class in one cycle. The net count must decide the outcome: it stays just under the stop level once, and reaches it exactly once.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   typedef enum logic [1:0] {
      REQ_NONE = 2'd0,
      REQ_HOLD = 2'd1,
      REQ_FREE = 2'd2
   } req_kind_e;
endpackage

// File: rtl/pfc_prio_track.sv
module pfc_prio_track
   import pfc_pkg::*;
#(
   parameter int unsigned BUF_BYTES      = 4096,
   parameter int unsigned HEADROOM_BYTES = 1536,
   parameter int unsigned RESUME_GAP     = 1024,
   parameter int unsigned BYTE_W         = 14,
   parameter int unsigned REFRESH_CYC    = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add_vld,
   input  logic [BYTE_W-1:0] add_bytes,
   input  logic              sub_vld,
   input  logic [BYTE_W-1:0] sub_bytes,
   output req_kind_e         req
);
   localparam int unsigned STOP_LVL = BUF_BYTES - HEADROOM_BYTES;
   localparam int unsigned GO_LVL   = STOP_LVL - RESUME_GAP;
   localparam int unsigned OCC_W    = $clog2(BUF_BYTES + 1) + 1;
   localparam int unsigned EW       = ((OCC_W > BYTE_W) ? OCC_W : BYTE_W) + 1;
   localparam int unsigned RF_W     = $clog2(REFRESH_CYC + 1);

   logic [OCC_W-1:0] occ, occ_nxt;
   logic [EW-1:0]    w_sum, w_sub, w_nxt;
   logic             held;
   logic [RF_W-1:0]  rf_cnt;

   always_comb begin
      w_sum   = EW'(occ) + (add_vld ? EW'(add_bytes) : '0);
      w_sub   = sub_vld ? EW'(sub_bytes) : '0;
      w_nxt   = (w_sub >= w_sum) ? '0 : (w_sum - w_sub);
      occ_nxt = (w_nxt > EW'({OCC_W{1'b1}})) ? {OCC_W{1'b1}} : w_nxt[OCC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ    <= '0;
         held   <= 1'b0;
         rf_cnt <= '0;
         req    <= REQ_NONE;
      end else begin
         occ <= occ_nxt;
         req <= REQ_NONE;
         if (!held) begin
            if (occ_nxt >= OCC_W'(STOP_LVL)) begin
               held   <= 1'b1;
               req    <= REQ_HOLD;
               rf_cnt <= '0;
            end
         end else if (occ_nxt < OCC_W'(GO_LVL)) begin
            held   <= 1'b0;
            req    <= REQ_FREE;
            rf_cnt <= '0;
         end else if (rf_cnt == RF_W'(REFRESH_CYC - 1)) begin
            req    <= REQ_HOLD;
            rf_cnt <= '0;
         end else begin
            rf_cnt <= rf_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pfc_stall_guard.sv
module pfc_stall_guard #(
   parameter int unsigned WD_TIMEOUT  = 100000,
   parameter int unsigned RESTORE_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic paused,
   input  logic nonempty,
   input  logic deq,
   output logic drop,
   output logic trip
);
   localparam int unsigned LIM = (WD_TIMEOUT > RESTORE_CYC) ? WD_TIMEOUT : RESTORE_CYC;
   localparam int unsigned TW  = $clog2(LIM + 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop <= 1'b0;
         trip <= 1'b0;
         cnt  <= '0;
      end else begin
         trip <= 1'b0;
         if (!drop) begin
            if (paused && nonempty && !deq) begin
               if (cnt == TW'(WD_TIMEOUT - 1)) begin
                  drop <= 1'b1;
                  trip <= 1'b1;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               cnt <= '0;
            end
         end else begin
            if (!paused && !nonempty) begin
               if (cnt == TW'(RESTORE_CYC - 1)) begin
                  drop <= 1'b0;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               cnt <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/pfc_evt_counter.sv
module pfc_evt_counter #(
   parameter int unsigned CW       = 16,
   parameter bit          CNT_WRAP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   generate
      if (CNT_WRAP) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (inc) cnt <= cnt + 1'b1;
         end
      end else begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt <= '0;
            else if (inc && (cnt != '1))    cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pfc_pause_engine.sv
module pfc_pause_engine
   import pfc_pkg::*;
#(
   parameter int unsigned NP              = 8,
   parameter int unsigned BYTE_W          = 14,
   parameter int unsigned BUF_BYTES       = 4096,
   parameter int unsigned HEADROOM_BYTES  = 1536,
   parameter int unsigned RESUME_GAP      = 1024,
   parameter int unsigned QW              = 16,
   parameter int unsigned PAUSE_QUANTA    = 16'hFFFF,
   parameter int unsigned CYC_PER_QUANTUM = 64,
   parameter int unsigned REFRESH_CYC     = 32768,
   parameter int unsigned WD_TIMEOUT      = 100000,
   parameter int unsigned RESTORE_CYC     = 10000,
   parameter int unsigned CW              = 16,
   parameter bit          CNT_WRAP        = 1'b0,
   localparam int unsigned PW             = (NP > 1) ? $clog2(NP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_enq_vld,
   input  logic [PW-1:0]    in_enq_prio,
   input  logic [BYTE_W-1:0] in_enq_bytes,
   input  logic             in_deq_vld,
   input  logic [PW-1:0]    in_deq_prio,
   input  logic [BYTE_W-1:0] in_deq_bytes,
   input  logic [NP-1:0]    eg_paused,
   input  logic [NP-1:0]    eg_nonempty,
   input  logic [NP-1:0]    eg_deq,
   input  logic             rx_pfc_vld,
   input  logic [NP-1:0]    rx_pfc_en,
   output logic             tx_pfc_vld,
   output logic [NP-1:0]    tx_pfc_en,
   output logic [NP*QW-1:0] tx_pfc_time,
   output logic [NP-1:0]    eg_drop_en,
   output logic [NP*CW-1:0] cnt_xoff_sent,
   output logic [NP*CW-1:0] cnt_rx_pfc,
   output logic [NP*CW-1:0] cnt_wd_trip
);
   generate
      if (NP < 2 || NP > 8) begin : g_bad_np
         $error("NP must lie between 2 and 8");
      end
      if (HEADROOM_BYTES >= BUF_BYTES) begin : g_bad_head
         $error("HEADROOM_BYTES must be below BUF_BYTES");
      end
      if (RESUME_GAP == 0 || RESUME_GAP >= BUF_BYTES - HEADROOM_BYTES) begin : g_bad_gap
         $error("RESUME_GAP must be nonzero and below the stop level");
      end
      if (PAUSE_QUANTA == 0 || longint'(PAUSE_QUANTA) >= (longint'(1) << QW)) begin : g_bad_q
         $error("PAUSE_QUANTA must be nonzero and fit QW bits");
      end
      if (REFRESH_CYC == 0 ||
          longint'(REFRESH_CYC) >= longint'(PAUSE_QUANTA) * longint'(CYC_PER_QUANTUM)) begin : g_bad_rf
         $error("REFRESH_CYC must be shorter than the advertised pause time");
      end
      if (WD_TIMEOUT == 0 || RESTORE_CYC == 0) begin : g_bad_wd
         $error("watchdog intervals must be nonzero");
      end
   endgenerate

   req_kind_e     trk_req [NP];
   logic [NP-1:0] trip;

   genvar i;
   generate
      for (i = 0; i < NP; i++) begin : g_prio
         pfc_prio_track #(
            .BUF_BYTES(BUF_BYTES), .HEADROOM_BYTES(HEADROOM_BYTES),
            .RESUME_GAP(RESUME_GAP), .BYTE_W(BYTE_W), .REFRESH_CYC(REFRESH_CYC)
         ) u_track (
            .clk(clk), .rst_n(rst_n),
            .add_vld(in_enq_vld && (in_enq_prio == PW'(i))),
            .add_bytes(in_enq_bytes),
            .sub_vld(in_deq_vld && (in_deq_prio == PW'(i))),
            .sub_bytes(in_deq_bytes),
            .req(trk_req[i])
         );

         assign tx_pfc_en[i] = (trk_req[i] != REQ_NONE);
         assign tx_pfc_time[i*QW +: QW] = (trk_req[i] == REQ_HOLD) ? QW'(PAUSE_QUANTA) : '0;

         pfc_stall_guard #(.WD_TIMEOUT(WD_TIMEOUT), .RESTORE_CYC(RESTORE_CYC)) u_guard (
            .clk(clk), .rst_n(rst_n),
            .paused(eg_paused[i]), .nonempty(eg_nonempty[i]), .deq(eg_deq[i]),
            .drop(eg_drop_en[i]), .trip(trip[i])
         );

         pfc_evt_counter #(.CW(CW), .CNT_WRAP(CNT_WRAP)) u_cnt_tx (
            .clk(clk), .rst_n(rst_n), .inc(trk_req[i] == REQ_HOLD),
            .cnt(cnt_xoff_sent[i*CW +: CW])
         );
         pfc_evt_counter #(.CW(CW), .CNT_WRAP(CNT_WRAP)) u_cnt_rx (
            .clk(clk), .rst_n(rst_n), .inc(rx_pfc_vld && rx_pfc_en[i]),
            .cnt(cnt_rx_pfc[i*CW +: CW])
         );
         pfc_evt_counter #(.CW(CW), .CNT_WRAP(CNT_WRAP)) u_cnt_wd (
            .clk(clk), .rst_n(rst_n), .inc(trip[i]),
            .cnt(cnt_wd_trip[i*CW +: CW])
         );
      end
   endgenerate

   assign tx_pfc_vld = |tx_pfc_en;
endmodule

// File: rtl/pfc_pause_engine_chk.sv
module pfc_pause_engine_chk #(
   parameter int unsigned NP           = 8,
   parameter int unsigned QW           = 16,
   parameter int unsigned PAUSE_QUANTA = 16'hFFFF,
   parameter int unsigned CW           = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NP-1:0]    eg_paused,
   input logic [NP-1:0]    eg_nonempty,
   input logic [NP-1:0]    eg_deq,
   input logic             tx_pfc_vld,
   input logic [NP-1:0]    tx_pfc_en,
   input logic [NP*QW-1:0] tx_pfc_time,
   input logic [NP-1:0]    eg_drop_en,
   input logic [NP*CW-1:0] cnt_wd_trip
);
   logic [NP-1:0] last_hold;

   p_vld_has_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pfc_vld |-> (tx_pfc_en != '0));

   genvar i;
   generate
      for (i = 0; i < NP; i++) begin : g_chk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) last_hold[i] <= 1'b0;
            else if (tx_pfc_en[i]) last_hold[i] <= (tx_pfc_time[i*QW +: QW] != '0);
         end

         p_time_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
            tx_pfc_en[i] |-> (tx_pfc_time[i*QW +: QW] == QW'(PAUSE_QUANTA) ||
                              tx_pfc_time[i*QW +: QW] == '0));

         p_idle_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_pfc_en[i] |-> (tx_pfc_time[i*QW +: QW] == '0));

         p_free_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_pfc_en[i] && tx_pfc_time[i*QW +: QW] == '0) |-> last_hold[i]);

         p_trip_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(eg_drop_en[i]) |-> $past(eg_paused[i] && eg_nonempty[i] && !eg_deq[i]));

         p_restore_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(eg_drop_en[i]) |-> $past(!eg_paused[i] && !eg_nonempty[i]));

         p_trip_counted_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(eg_drop_en[i]) && cnt_wd_trip[i*CW +: CW] != '1)
               |=> (cnt_wd_trip[i*CW +: CW] != $past(cnt_wd_trip[i*CW +: CW])));
      end
   endgenerate
endmodule

bind pfc_pause_engine pfc_pause_engine_chk #(
   .NP(NP), .QW(QW), .PAUSE_QUANTA(PAUSE_QUANTA), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .eg_paused(eg_paused), .eg_nonempty(eg_nonempty),
   .eg_deq(eg_deq), .tx_pfc_vld(tx_pfc_vld), .tx_pfc_en(tx_pfc_en),
   .tx_pfc_time(tx_pfc_time), .eg_drop_en(eg_drop_en), .cnt_wd_trip(cnt_wd_trip)
);

// File: tb/pfc_pause_engine_test.sv
module pfc_pause_engine_test;
   localparam int CLK_NS   = 10;
   localparam int NP       = 8;
   localparam int BYTE_W   = 8;
   localparam int QW       = 16;
   localparam int QUANTA   = 100;
   localparam int REFRESH  = 20;
   localparam int WD       = 10;
   localparam int RESTORE  = 5;
   localparam int CW       = 8;

   typedef struct packed {
      logic       ev; logic [2:0] ep; logic [7:0] eb;
      logic       dv; logic [2:0] dp; logic [7:0] db;
      logic [7:0] xen; logic [7:0] xq;
   } vec_t;

   // stop level 120, restart level 80
   localparam vec_t VT [14] = '{
      '{1'b1,3'd2,8'd60,  1'b0,3'd0,8'd0,   8'h00,8'h00},  // R2 below stop
      '{1'b1,3'd2,8'd60,  1'b0,3'd0,8'd0,   8'h04,8'h04},  // R3 reach stop
      '{1'b1,3'd2,8'd10,  1'b0,3'd0,8'd0,   8'h00,8'h00},  // R3 no repeat
      '{1'b0,3'd0,8'd0,   1'b1,3'd2,8'd40,  8'h00,8'h00},  // R4 in gap
      '{1'b0,3'd0,8'd0,   1'b1,3'd2,8'd20,  8'h04,8'h00},  // R4 release
      '{1'b1,3'd5,8'd119, 1'b0,3'd0,8'd0,   8'h00,8'h00},  // R3 one below
      '{1'b1,3'd5,8'd1,   1'b1,3'd2,8'd50,  8'h20,8'h20},  // R2 isolation
      '{1'b1,3'd3,8'd120, 1'b1,3'd5,8'd100, 8'h28,8'h08},  // R10 merged
      '{1'b0,3'd0,8'd0,   1'b1,3'd3,8'd200, 8'h08,8'h00},  // R2 floor
      '{1'b1,3'd3,8'd120, 1'b0,3'd0,8'd0,   8'h08,8'h08},  // R2 floor proof
      '{1'b0,3'd0,8'd0,   1'b1,3'd3,8'd120, 8'h08,8'h00},  // R4
      '{1'b1,3'd6,8'd130, 1'b1,3'd6,8'd20,  8'h00,8'h00},  // R2 net 110
      '{1'b1,3'd6,8'd10,  1'b1,3'd6,8'd0,   8'h40,8'h40},  // R2 net 120
      '{1'b0,3'd0,8'd0,   1'b1,3'd6,8'd120, 8'h40,8'h00}   // R4
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_enq_vld = 0, in_deq_vld = 0;
   logic [2:0] in_enq_prio = '0, in_deq_prio = '0;
   logic [BYTE_W-1:0] in_enq_bytes = '0, in_deq_bytes = '0;
   logic [NP-1:0] eg_paused = '0, eg_nonempty = '0, eg_deq = '0, rx_pfc_en = '0;
   logic rx_pfc_vld = 0;
   logic tx_pfc_vld;
   logic [NP-1:0] tx_pfc_en, eg_drop_en;
   logic [NP*QW-1:0] tx_pfc_time;
   logic [NP*CW-1:0] cnt_xoff_sent, cnt_rx_pfc, cnt_wd_trip;

   int tests = 0, fails = 0;

   always #(CLK_NS/2) clk = ~clk;

   pfc_pause_engine #(
      .NP(NP), .BYTE_W(BYTE_W), .BUF_BYTES(200), .HEADROOM_BYTES(80), .RESUME_GAP(40),
      .QW(QW), .PAUSE_QUANTA(QUANTA), .CYC_PER_QUANTUM(1), .REFRESH_CYC(REFRESH),
      .WD_TIMEOUT(WD), .RESTORE_CYC(RESTORE), .CW(CW), .CNT_WRAP(1'b0)
   ) uut (.*);

   task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [NP*QW-1:0] times(input logic [7:0] q);
      logic [NP*QW-1:0] t = '0;
      for (int k = 0; k < NP; k++) if (q[k]) t[k*QW +: QW] = QW'(QUANTA);
      return t;
   endfunction

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 chk("R1 in reset", {tx_pfc_vld, tx_pfc_en, eg_drop_en, cnt_xoff_sent, cnt_rx_pfc, cnt_wd_trip}, '0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1
      chk("R1 after release", {tx_pfc_vld, tx_pfc_en, tx_pfc_time, eg_drop_en}, '0);

      for (int v = 0; v < 14; v++) begin
         @(negedge clk);
         in_enq_vld = VT[v].ev; in_enq_prio = VT[v].ep; in_enq_bytes = VT[v].eb;
         in_deq_vld = VT[v].dv; in_deq_prio = VT[v].dp; in_deq_bytes = VT[v].db;
         @(posedge clk); #1
         chk($sformatf("R3/R4 vector %0d", v), {tx_pfc_vld, tx_pfc_en, tx_pfc_time},
             {|VT[v].xen, VT[v].xen, times(VT[v].xq)});
      end
      @(negedge clk) begin in_enq_vld = 0; in_deq_vld = 0; end

      chk("R9 hold counts p2 p3 p6", {cnt_xoff_sent[2*CW +: CW], cnt_xoff_sent[3*CW +: CW],
          cnt_xoff_sent[6*CW +: CW]}, {8'd1, 8'd2, 8'd1});

      // R5 refresh while held
      @(negedge clk) begin in_enq_vld = 1; in_enq_prio = 3'd1; in_enq_bytes = 8'd150; end
      @(posedge clk); #1 chk("R5 initial hold", {tx_pfc_en, tx_pfc_time}, {8'h02, times(8'h02)});
      @(negedge clk) in_enq_vld = 0;
      begin
         int extra = 0;
         for (int c = 0; c < REFRESH - 1; c++) begin
            @(posedge clk); #1 if (tx_pfc_vld) extra++;
         end
         chk("R5 quiet before refresh", extra, 0);
      end
      @(posedge clk); #1 chk("R5 refresh", {tx_pfc_vld, tx_pfc_en, tx_pfc_time}, {1'b1, 8'h02, times(8'h02)});
      @(negedge clk) begin in_deq_vld = 1; in_deq_prio = 3'd1; in_deq_bytes = 8'd150; end
      @(posedge clk); #1 chk("R4 release p1", {tx_pfc_en, tx_pfc_time}, {8'h02, times(8'h00)});
      @(negedge clk) in_deq_vld = 0;
      @(posedge clk); #1 chk("R9 p1 holds incl refresh", cnt_xoff_sent[1*CW +: CW], 8'd2);

      // R9 received frames
      @(negedge clk) begin rx_pfc_vld = 1; rx_pfc_en = 8'h81; end
      @(negedge clk);
      @(negedge clk) begin rx_pfc_vld = 0; rx_pfc_en = 8'h00; end
      chk("R9 rx counts", {cnt_rx_pfc[7*CW +: CW], cnt_rx_pfc[1*CW +: CW], cnt_rx_pfc[0 +: CW]},
          {8'd2, 8'd0, 8'd2});

      // R6 / R8 watchdog on queue 4
      @(negedge clk) begin eg_paused[4] = 1; eg_nonempty[4] = 1; end
      repeat (WD - 1) @(posedge clk);
      #1 chk("R6 not yet tripped", eg_drop_en, 8'h00);
      @(negedge clk) eg_deq[4] = 1;
      @(negedge clk) eg_deq[4] = 0;
      repeat (WD - 1) @(posedge clk);
      #1 chk("R6 dequeue restarted count", eg_drop_en, 8'h00);
      @(posedge clk); #1 chk("R6 R8 tripped while paused", eg_drop_en, 8'h10);
      repeat (30) @(posedge clk);
      #1 chk("R8 holds under partner pause", eg_drop_en, 8'h10);
      chk("R9 trip count", {cnt_wd_trip[4*CW +: CW], cnt_wd_trip[3*CW +: CW]}, {8'd1, 8'd0});

      // R7 restore
      @(negedge clk) eg_nonempty[4] = 0;
      repeat (10) @(posedge clk);
      #1 chk("R7 stays while paused", eg_drop_en, 8'h10);
      @(negedge clk) eg_paused[4] = 0;
      repeat (RESTORE - 1) @(posedge clk);
      #1 chk("R7 before restore", eg_drop_en, 8'h10);
      @(posedge clk); #1 chk("R7 restored", eg_drop_en, 8'h00);

      summary();
      $finish;
   end
endmodule